// File: doc/BRIEF.md
# Byte-Wide SPI Master with Control Register

This block is a byte-oriented SPI master. Software sets it up through one eight-bit control register and exchanges bytes through a data location on a small register bus. The control register holds several settings: the enable, the master select, clock polarity, clock phase and bit order. It also holds the automatic slave-select enable and two interrupt enables. A write to the data location queues a byte. The engine moves the byte into its shifter as soon as it is idle. It then runs sixteen SCK edges, sending on MOSI and capturing MISO, and posts the received byte back at the same data location.

Three status flags report progress: transfer complete, transmit empty and mode fault. The mode-fault flag is set from an external input pulse. An interrupt request is formed from the flags that are enabled. A change to any setting that shapes the frame stops a transfer in flight at once. Clearing the enable also wipes every flag.

Top module: `spim_top`

## Requirements
- R1: After reset the control register reads 0x04 (only clock phase set), the status reads 0, SCK and MOSI are low, ss_n is high and irq is low.
- R2: The control register can be read and written at any time. Its bits, from bit 7 down to bit 0, are: receive-interrupt enable, run enable, transmit-interrupt enable, master select, clock polarity, clock phase, slave-select output enable, LSB-first. Address 0 is control, address 1 is status and address 2 is data.
- R3: When run enable and master select are both 1, a write to address 2 queues a byte. The idle engine then loads it and sets transmit-empty (status bit 1). It drives exactly 16 SCK edges spaced DIV clock cycles apart, and sets transfer-complete (status bit 0) after the 16th edge.
- R4: When no transfer is running, SCK rests at the clock polarity bit: low for 0, high for 1.
- R5: With clock phase 0, bits are sampled on SCK edges 1, 3, …, 15. With clock phase 1, they are sampled on edges 2, 4, …, 16. MOSI is stable at every sampling edge.
- R6: LSB-first = 0 sends and receives bit 7 first. LSB-first = 1 sends and receives bit 0 first. In both cases a read of address 2 returns the received byte with its first-arriving MSB-order bit in bit 7, so that register contents keep the same bit weights.
- R7: ss_n is driven low for the length of a transfer only when master select, slave-select output enable and fault_det_en are all 1. Otherwise ss_n stays high.
- R8: In master mode, writing a new value of clock polarity, clock phase, LSB-first or slave-select output enable during a transfer aborts it. No further SCK edges follow, SCK returns to idle, ss_n goes high and the flags keep their values.
- R9: Clearing run enable stops any transfer and clears all three flags, and they stay clear while run enable is 0.
- R10: Flipping master select in either direction stops a transfer. With master select 0, a queued byte is not loaded and produces no SCK edges.
- R11: irq is 1 exactly when (receive-interrupt enable and (transfer-complete or mode-fault)) or (transmit-interrupt enable and transmit-empty) held in the previous cycle.
- R12: A fault_in pulse while enabled sets mode-fault (status bit 2). Writing a 1 to status bit 0 or bit 2 clears that flag.
- R13: reg_rdata presents the location addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| fault_in | input | 1 | Mode-fault event pulse |
| fault_det_en | input | 1 | Mode-fault detection enable, gates automatic slave select |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| irq | output | 1 | Interrupt request |

## Verification
An edge counter that has drifted shows as a burst of SCK edges other than sixteen, or as a transfer-complete flag that is set early or late. Both are visible within one frame, which is 16·DIV cycles. A shifter holding the wrong order or the wrong phase shows on the next sampling edge as a mismatched MOSI bit, and later as a wrong byte read back. A stale busy state after an abort reveals itself as SCK edges or a low ss_n within DIV cycles of the control write. Flags left set after a disable appear on the next status read and at irq one cycle later.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef struct packed {
    logic irq_en;
    logic run_en;
    logic txirq_en;
    logic host_sel;
    logic clk_pol;
    logic clk_pha;
    logic sel_out_en;
    logic lsb_first;
  } spim_ctl_t;

  localparam logic [7:0] CTL_RESET = 8'h04;
  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam int ST_DONE  = 0;
  localparam int ST_TXE   = 1;
  localparam int ST_FAULT = 2;
endpackage

// File: rtl/spim_edgegen.sv
module spim_edgegen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy || cnt == '0) cnt <= CW'(DIV - 1);
    else                           cnt <= cnt - 1'b1;
  end

  assign tick = busy && (cnt == '0);
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fault_in,
  input  logic              load,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] rx_byte,
  output spim_ctl_t         ctl,
  output logic [DATA_W-1:0] txbuf,
  output logic              pending,
  output logic              abort,
  output logic              irq
);
  spim_ctl_t         ctl_q, new_ctl;
  logic              done_q, txe_q, fault_q;
  logic [DATA_W-1:0] rx_q;
  logic              wr_ctl, wr_stat, wr_data, fmt_chg;

  assign wr_ctl  = reg_wr && reg_addr == A_CTL;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign wr_data = reg_wr && reg_addr == A_DATA;
  assign new_ctl = spim_ctl_t'(reg_wdata[7:0]);
  assign fmt_chg = {ctl_q.clk_pol, ctl_q.clk_pha, ctl_q.sel_out_en, ctl_q.lsb_first} !=
                   {new_ctl.clk_pol, new_ctl.clk_pha, new_ctl.sel_out_en, new_ctl.lsb_first};
  assign abort   = wr_ctl && ((ctl_q.run_en && !new_ctl.run_en) ||
                              (ctl_q.host_sel != new_ctl.host_sel) ||
                              (ctl_q.host_sel && fmt_chg));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= spim_ctl_t'(CTL_RESET);
      done_q    <= 1'b0;
      txe_q     <= 1'b0;
      fault_q   <= 1'b0;
      pending   <= 1'b0;
      txbuf     <= '0;
      rx_q      <= '0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_ctl)  ctl_q <= new_ctl;
      if (wr_data) txbuf <= reg_wdata;
      if (!ctl_q.run_en) begin
        done_q  <= 1'b0;
        txe_q   <= 1'b0;
        fault_q <= 1'b0;
        pending <= 1'b0;
      end else begin
        if (load) begin
          txe_q   <= 1'b1;
          pending <= 1'b0;
        end
        if (wr_data) begin
          txe_q   <= 1'b0;
          pending <= 1'b1;
        end
        if (wr_stat && reg_wdata[ST_DONE])  done_q  <= 1'b0;
        if (wr_stat && reg_wdata[ST_FAULT]) fault_q <= 1'b0;
        if (xfer_done) begin
          done_q <= 1'b1;
          rx_q   <= rx_byte;
        end
        if (fault_in) fault_q <= 1'b1;
      end
      case (reg_addr)
        A_CTL:   reg_rdata <= DATA_W'(ctl_q);
        A_STAT:  reg_rdata <= DATA_W'({fault_q, txe_q, done_q});
        A_DATA:  reg_rdata <= rx_q;
        default: reg_rdata <= '0;
      endcase
      irq <= (ctl_q.irq_en & (done_q | fault_q)) | (ctl_q.txirq_en & txe_q);
    end
  end

  assign ctl = ctl_q;

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(!ctl_q.run_en) |-> (!done_q && !txe_q && !fault_q)); // R9
  AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(load && !wr_data && ctl_q.run_en) |-> txe_q); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!ctl_q.irq_en && !ctl_q.txirq_en) |-> !irq); // R11
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (rst)
    $past(wr_stat && reg_wdata[ST_DONE] && !xfer_done) |-> !done_q); // R12
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  spim_ctl_t         ctl,
  input  logic [DATA_W-1:0] txbuf,
  input  logic              pending,
  input  logic              abort,
  input  logic              tick,
  input  logic              miso,
  input  logic              fault_det_en,
  output logic              busy,
  output logic              load,
  output logic              xfer_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CW    = $clog2(EDGES);

  logic              busy_q, sck_q, mosi_q, ss_q;
  logic [CW-1:0]     ecnt;
  logic [DATA_W-1:0] txs, rxs, rx_next, tx_shift, buf_shift;
  logic              start, smp, last, tx_out, first_out, auto_ss;

  always_comb begin
    start     = !busy_q && pending && ctl.run_en && ctl.host_sel && !abort;
    smp       = ctl.clk_pha ? ecnt[0] : !ecnt[0];
    last      = ecnt == CW'(EDGES - 1);
    rx_next   = ctl.lsb_first ? {miso, rxs[DATA_W-1:1]} : {rxs[DATA_W-2:0], miso};
    tx_out    = ctl.lsb_first ? txs[0] : txs[DATA_W-1];
    tx_shift  = ctl.lsb_first ? (txs >> 1) : (txs << 1);
    first_out = ctl.lsb_first ? txbuf[0] : txbuf[DATA_W-1];
    buf_shift = ctl.lsb_first ? (txbuf >> 1) : (txbuf << 1);
    auto_ss   = ctl.host_sel && ctl.sel_out_en && fault_det_en;
  end

  assign load      = start;
  assign xfer_done = busy_q && tick && last && !abort;
  assign rx_byte   = smp ? rx_next : rxs;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ecnt   <= '0;
      txs    <= '0;
      rxs    <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      ss_q   <= 1'b1;
    end else if (abort) begin
      busy_q <= 1'b0;
      sck_q  <= ctl.clk_pol;
      ss_q   <= 1'b1;
    end else if (!busy_q) begin
      sck_q <= ctl.clk_pol;
      ss_q  <= 1'b1;
      if (start) begin
        busy_q <= 1'b1;
        ecnt   <= '0;
        rxs    <= '0;
        ss_q   <= !auto_ss;
        if (ctl.clk_pha) txs <= txbuf;
        else begin
          mosi_q <= first_out;
          txs    <= buf_shift;
        end
      end
    end else if (tick) begin
      sck_q <= !sck_q;
      ecnt  <= ecnt + 1'b1;
      if (smp) rxs <= rx_next;
      else if (!last) begin
        mosi_q <= tx_out;
        txs    <= tx_shift;
      end
      if (last) begin
        busy_q <= 1'b0;
        ss_q   <= 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign sck  = sck_q;
  assign mosi = mosi_q;
  assign ss_n = ss_q;

  AST_SS_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> ss_q); // R7
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
    $past(abort) |-> !busy_q); // R8
  AST_SLAVE_NOSTART: assert property (@(posedge clk) disable iff (rst)
    $past(!ctl.host_sel && !busy_q) |-> !busy_q); // R10
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fault_in,
  input  logic              fault_det_en,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              irq
);
  spim_ctl_t         ctl;
  logic [DATA_W-1:0] txbuf, rx_byte;
  logic              pending, abort, load, xfer_done, busy, tick;

  spim_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_in(fault_in),
    .load(load), .xfer_done(xfer_done), .rx_byte(rx_byte), .ctl(ctl),
    .txbuf(txbuf), .pending(pending), .abort(abort), .irq(irq)
  );

  spim_edgegen #(.DIV(DIV)) u_edge (
    .clk(clk), .rst(rst), .busy(busy), .tick(tick)
  );

  spim_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .ctl(ctl), .txbuf(txbuf), .pending(pending),
    .abort(abort), .tick(tick), .miso(miso), .fault_det_en(fault_det_en),
    .busy(busy), .load(load), .xfer_done(xfer_done), .rx_byte(rx_byte),
    .sck(sck), .mosi(mosi), .ss_n(ss_n)
  );

  AST_SCK_MOVES: assert property (@(posedge clk) disable iff (rst)
    $past(busy && tick && !abort) |-> (sck != $past(sck))); // R3
endmodule

// File: tb/spim_top_test.sv
module spim_top_test;
  localparam int DW  = 8;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    reg_addr = 2'd0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          fault_in = 1'b0;
  logic          fault_det_en = 1'b0;
  logic          miso = 1'b0;
  logic          sck, mosi, ss_n, irq;

  always #5 clk = ~clk;

  spim_top #(.DATA_W(DW), .DIV(DIV)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_in(fault_in),
    .fault_det_en(fault_det_en), .miso(miso), .sck(sck), .mosi(mosi),
    .ss_n(ss_n), .irq(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic b_pol = 1'b0, b_pha = 1'b1, b_lsb = 1'b0;
  logic prev_sck = 1'b0, ss_low_seen = 1'b0;
  int edge_n = 0, smp_k = 0, drv_k = 0, since = 0, bad_gap = 0;
  logic [7:0] got_mosi = '0, sl_byte = '0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  // bench slave model: counts SCK edges, records MOSI, drives MISO
  always @(negedge clk) if (!rst) begin
    since++;
    if (sck !== prev_sck) begin
      edge_n++;
      if (edge_n > 1 && since != DIV) bad_gap++;
      since = 0;
      if ((edge_n % 2 == 1) != b_pha) begin
        if (smp_k < 8) begin
          if (b_lsb) got_mosi[smp_k] = mosi;
          else       got_mosi[7-smp_k] = mosi;
        end
        smp_k++;
      end else if (drv_k < 8) begin
        miso = b_lsb ? sl_byte[drv_k] : sl_byte[7-drv_k];
        drv_k++;
      end
    end
    if (edge_n > 0 && ss_n == 1'b0) ss_low_seen = 1'b1;
    prev_sck = sck;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1'b0;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [7:0] ctl_val(input logic ie, run, tie, host, pol, pha, soe, lsb);
    return {ie, run, tie, host, pol, pha, soe, lsb};
  endfunction

  task automatic arm(input logic [7:0] sl);
    edge_n = 0; smp_k = 0; bad_gap = 0; since = 0;
    drv_k = b_pha ? 0 : 1;
    got_mosi = '0; ss_low_seen = 1'b0; sl_byte = sl;
    miso = b_pha ? 1'b0 : (b_lsb ? sl[0] : sl[7]);
    prev_sck = sck;
  endtask

  task automatic setup(input logic ie, tie, pol, pha, soe, lsb, fden);
    b_pol = pol; b_pha = pha; b_lsb = lsb; fault_det_en = fden;
    wr(2'd0, ctl_val(ie, 1'b1, tie, 1'b1, pol, pha, soe, lsb));
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, sl, input logic ie, tie, pol, pha, soe, lsb, fden);
    logic [7:0] st, rx;
    setup(ie, tie, pol, pha, soe, lsb, fden);
    arm(sl);
    wr(2'd2, tx);
    st = '0;
    for (int i = 0; i < 100 && !st[0]; i++) rd(2'd1, st);
    @(negedge clk);
    chk("R3", "edge count", edge_n, 16);
    chk("R3", "edge spacing errors", bad_gap, 0);
    chk("R3", "status after frame", st, 8'h03);
    chk("R5", "mosi byte at sample edges", got_mosi, tx);
    chk("R4", "sck idle level", sck, pol);
    chk("R7", "ss low during frame", ss_low_seen, soe & fden);
    chk("R7", "ss_n after frame", ss_n, 1'b1);
    chk("R11", "irq after frame", irq, ie | tie);
    rd(2'd2, rx);
    chk("R6", "received byte", rx, sl);
    wr(2'd1, 8'h05);
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < 400 && edge_n < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int e2;
    int unsigned seedv;
    seedv = $urandom(32'd7781);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "sck", sck, 1'b0);
    chk("R1", "mosi", mosi, 1'b0);
    chk("R1", "ss_n", ss_n, 1'b1);
    chk("R1", "irq", irq, 1'b0);
    rd(2'd0, v); chk("R1", "control reset", v, 8'h04);
    rd(2'd1, v); chk("R1", "status reset", v, 8'h00);
    // R2 / R13 control readback on the next read
    wr(2'd0, 8'hA5);
    rd(2'd0, v); chk("R2", "control readback", v, 8'hA5);
    chk("R13", "read latency one cycle", reg_rdata, 8'hA5);
    chk("R4", "sck idle with pol 0", sck, 1'b0);

    // directed frames over the four clock modes and both orders
    xfer(8'hA3, 8'h5C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    xfer(8'hA3, 8'h5C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    xfer(8'h81, 8'h3E, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    xfer(8'h01, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    xfer(8'h6D, 8'hC4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

    // constrained random frames
    for (int k = 0; k < 30; k++) begin
      logic [7:0] t, s;
      logic [6:0] m;
      t = 8'($urandom()); s = 8'($urandom()); m = 7'($urandom());
      xfer(t, s, m[0], m[1], m[2], m[3], m[4], m[5], m[6]);
    end

    // R8 abort by a format change in flight
    setup(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    arm(8'hF0);
    wr(2'd2, 8'h99);
    wait_edges(5);
    wr(2'd0, ctl_val(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1));
    repeat (2) @(negedge clk);
    e2 = edge_n;
    repeat (10 * DIV) @(negedge clk);
    chk("R8", "edges after abort", edge_n, e2);
    chk("R8", "sck idle after abort", sck, 1'b1);
    chk("R8", "ss_n after abort", ss_n, 1'b1);
    rd(2'd1, v); chk("R8", "flags kept after abort", v, 8'h02);

    // R12 fault flag, irq from it, write-one-to-clear
    wr(2'd0, ctl_val(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk); fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
    rd(2'd1, v); chk("R12", "fault flag set", v, 8'h06);
    chk("R11", "irq from fault", irq, 1'b1);
    wr(2'd1, 8'h04);
    rd(2'd1, v); chk("R12", "fault flag cleared", v, 8'h02);

    // R9 disable mid-frame clears flags and stops SCK
    setup(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    arm(8'h11);
    wr(2'd2, 8'h22);
    wait_edges(6);
    wr(2'd0, ctl_val(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
    repeat (2) @(negedge clk);
    e2 = edge_n;
    @(negedge clk); fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
    repeat (10 * DIV) @(negedge clk);
    chk("R9", "edges after disable", edge_n, e2);
    chk("R9", "ss_n after disable", ss_n, 1'b1);
    chk("R9", "irq after disable", irq, 1'b0);
    rd(2'd1, v); chk("R9", "flags cleared", v, 8'h00);

    // R10 master select flip aborts; slave mode loads nothing
    setup(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    arm(8'h77);
    wr(2'd2, 8'h3C);
    wait_edges(3);
    wr(2'd0, ctl_val(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    e2 = edge_n;
    wr(2'd1, 8'h05);
    wr(2'd2, 8'h5A);
    repeat (20 * DIV) @(negedge clk);
    chk("R10", "edges in slave mode", edge_n, e2);
    rd(2'd1, v); chk("R10", "queued byte not loaded", v, 8'h00);
    chk("R11", "irq with tx empty clear", irq, 1'b0);
    wr(2'd0, 8'h04);
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end
endmodule